// File: doc/BRIEF.md
# UART transmit-empty interrupt source

This block is the transmit-empty interrupt source of a 16550-style UART register file. It decodes a small CPU register bus and keeps three pieces of state: the interrupt enable bits, the FIFO enable, and a count of bytes waiting for the transmitter. From that state it produces the interrupt line, the interrupt identification code and the line-status "transmit holding empty" flag. The transmitter reports each byte it takes through a one-cycle pulse.

A static mode input picks the re-arm policy that applies after the interrupt has been acknowledged by an identification read. With `rearm_on_enable_i` high, toggling the enable bit from 0 to 1 while the holding store is empty raises the interrupt again. With it low, the interrupt stays quiet until software writes new data and the store drains again. Software that cannot rely on either policy can poll the line-status flag, which never depends on interrupt state.

Register addresses are 0 (holding write), 1 (enable), 2 (identification read, FIFO control write) and 5 (line status). Reads of any other address return 0.

Top module: `uart_thre_irq`

## Requirements
- R1: After reset, the enable register reads 0, the FIFO is disabled, the holding store is empty, line-status bit 5 is 1, `irq_o` is 0 and `iir_id_o` is 0x1.
- R2: FIFO control write bit 0 selects a capacity of FIFO_DEPTH bytes (1) or one byte (0). A holding write beyond capacity is dropped unless a byte is taken in the same cycle. A control write with bit 2 set, or one that changes bit 0, empties the store. Identification bits 7:6 read 11 while the FIFO is enabled and 00 otherwise.
- R3: Identification bits 3:0 read 0x2 while the transmit-empty interrupt is pending and 0x1 otherwise, so bit 0 is 1 exactly when nothing is pending. `irq_o` is 1 exactly when it is pending.
- R4: A read strobe at address 2 while the interrupt is pending returns 0x2 and clears the interrupt on the following edge.
- R5: With enable bit 1 set, the interrupt is raised when the store goes from non-empty to empty. It is also raised when enable bit 1 goes from 0 to 1 while the store is empty, provided no identification read has acknowledged it since the last holding write.
- R6: With `rearm_on_enable_i`=0, after an acknowledging identification read, clearing and then setting enable bit 1 does not raise the interrupt. It is raised again only after a holding write followed by the store becoming empty.
- R7: With `rearm_on_enable_i`=1, every 0-to-1 write of enable bit 1 while the store is empty raises the interrupt, even with no holding write in between.
- R8: Line-status bit 5 and `thre_o` are 1 exactly when the holding store is empty, whatever the interrupt state. Other line-status bits read 0.
- R9: A holding write clears a pending interrupt on the next edge.
- R10: Reads of addresses other than 2 leave the interrupt state unchanged.
- R11: Writing enable bit 1 as 0 clears a pending interrupt. The enable register reads back its low four written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tx_take_i | input | 1 | Transmitter took one byte from the store |
| rearm_on_enable_i | input | 1 | Static re-arm policy: 1 enable edge, 0 needs new data |
| irq_o | output | 1 | Transmit-empty interrupt |
| iir_id_o | output | 4 | Interrupt identification code |
| thre_o | output | 1 | Holding store empty |

## Verification
The hardest state to reach is an acknowledged interrupt with the store still empty, followed by an enable toggle. That state needs an identification read while the interrupt is pending, with no holding write after it. The directed stimulus builds this exact sequence (enable, read identification, disable, enable, read again) and replays it under both policies after a reset, then adds a holding write and a drain to show the write policy re-arming. A pseudo-random phase then mixes reads, enable toggles, FIFO control writes and transmitter takes against the behavioural model on every cycle.

// File: rtl/uart_thre_pkg.sv
package uart_thre_pkg;
  localparam logic [2:0] A_THR = 3'd0;
  localparam logic [2:0] A_IER = 3'd1;
  localparam logic [2:0] A_IIR = 3'd2;  // read: identification, write: FIFO control
  localparam logic [2:0] A_LSR = 3'd5;
  localparam logic [3:0] IIR_NONE = 4'h1;
  localparam logic [3:0] IIR_THRE = 4'h2;
endpackage

// File: rtl/uart_tx_level.sv
module uart_tx_level #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fifo_en_i,
  input  logic flush_i,
  input  logic push_i,
  input  logic pop_i,
  output logic empty_o,
  output logic empty_next_o,
  output logic empty_evt_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP_FIFO = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d, cnt_pop, cap;
  logic          pop_ok;

  assign cap     = fifo_en_i ? CAP_FIFO : CAP_ONE;
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign cnt_pop = cnt_q - CW'(pop_ok);

  always_comb begin
    cnt_d = cnt_pop;
    if (flush_i)                      cnt_d = '0;
    else if (push_i && cnt_pop < cap) cnt_d = cnt_pop + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assign empty_o      = (cnt_q == '0);
  assign empty_next_o = (cnt_d == '0);
  assign empty_evt_o  = !empty_o && empty_next_o;

  // R8: last byte taken with no refill leaves the store empty
  a_r8_drain_to_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_q == CW'(1) && !push_i) |=> empty_o);
  // R2: a push that fits makes the store non-empty
  a_r2_push_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i && empty_o) |=> !empty_o);
endmodule

// File: rtl/uart_thre_src.sv
module uart_thre_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rearm_on_enable_i,
  input  logic ier_thre_i,    // enable bit 1 as it will be after this edge
  input  logic ier_rise_i,
  input  logic ier_off_i,
  input  logic thr_wr_i,
  input  logic iir_rd_i,
  input  logic empty_next_i,
  input  logic empty_evt_i,
  output logic pend_o
);
  logic pend_q, spent_q, set_now, clr_now, ack_now;

  assign ack_now = iir_rd_i && pend_q;
  assign set_now = ier_thre_i &&
                   (empty_evt_i ||
                    (ier_rise_i && empty_next_i && (rearm_on_enable_i || !spent_q)));
  assign clr_now = ack_now || thr_wr_i || ier_off_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      spent_q <= 1'b0;
    end else begin
      if (set_now)      pend_q <= 1'b1;
      else if (clr_now) pend_q <= 1'b0;
      // spent: acknowledged and not refilled since
      if (thr_wr_i)                 spent_q <= 1'b0;
      else if (ack_now && !set_now) spent_q <= 1'b1;
    end

  assign pend_o = pend_q;

  a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && pend_q && !empty_evt_i && !ier_rise_i) |=> !pend_q);
  a_r6_no_rearm_on_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rearm_on_enable_i && spent_q && ier_rise_i && !empty_evt_i && !thr_wr_i) |=> !pend_q);
  a_r7_rearm_on_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rearm_on_enable_i && ier_rise_i && ier_thre_i && empty_next_i) |=> pend_q);
  a_r11_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_off_i |=> !pend_q);
endmodule

// File: rtl/uart_thre_irq.sv
module uart_thre_irq
  import uart_thre_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       tx_take_i,
  input  logic       rearm_on_enable_i,
  output logic       irq_o,
  output logic [3:0] iir_id_o,
  output logic       thre_o
);
  logic [3:0] ier_q, ier_d;
  logic       fifo_en_q, fifo_en_d;
  logic       thr_wr, ier_wr, fcr_wr, iir_rd, flush;
  logic       empty, empty_next, empty_evt, pend;

  assign thr_wr = wr_i && addr_i == A_THR;
  assign ier_wr = wr_i && addr_i == A_IER;
  assign fcr_wr = wr_i && addr_i == A_IIR;
  assign iir_rd = rd_i && addr_i == A_IIR;
  assign flush  = fcr_wr && (wdata_i[2] || wdata_i[0] != fifo_en_q);

  assign ier_d     = ier_wr ? wdata_i[3:0] : ier_q;
  assign fifo_en_d = fcr_wr ? wdata_i[0]   : fifo_en_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ier_q     <= '0;
      fifo_en_q <= 1'b0;
    end else begin
      ier_q     <= ier_d;
      fifo_en_q <= fifo_en_d;
    end

  uart_tx_level #(.DEPTH(FIFO_DEPTH)) u_level (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_en_i    (fifo_en_q),
    .flush_i      (flush),
    .push_i       (thr_wr),
    .pop_i        (tx_take_i),
    .empty_o      (empty),
    .empty_next_o (empty_next),
    .empty_evt_o  (empty_evt)
  );

  uart_thre_src u_src (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .rearm_on_enable_i (rearm_on_enable_i),
    .ier_thre_i        (ier_d[1]),
    .ier_rise_i        (ier_wr && !ier_q[1] && wdata_i[1]),
    .ier_off_i         (ier_wr && !wdata_i[1]),
    .thr_wr_i          (thr_wr),
    .iir_rd_i          (iir_rd),
    .empty_next_i      (empty_next),
    .empty_evt_i       (empty_evt),
    .pend_o            (pend)
  );

  assign irq_o    = pend;
  assign iir_id_o = pend ? IIR_THRE : IIR_NONE;
  assign thre_o   = empty;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_IER:   rdata_o = {4'b0, ier_q};
      A_IIR:   rdata_o = {{2{fifo_en_q}}, 2'b00, iir_id_o};
      A_LSR:   rdata_o = {2'b00, empty, 5'b0};
      default: rdata_o = '0;
    endcase
  end

  a_r9_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr |=> !irq_o);
  a_r10_other_read_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != A_IIR && !wr_i && !tx_take_i) |=> $stable(irq_o));
  a_r3_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ier_q[1]);
endmodule

// File: tb/tb_uart_thre_irq.sv
module tb_uart_thre_irq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0, take = 1'b0, mode = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, thre;
  logic [3:0] iid;

  int vectors = 0, miscompares = 0;
  int m_cnt, m_fifo, m_ier, m_pend, m_spent;
  int unsigned lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_thre_irq #(.FIFO_DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_take_i(take),
    .rearm_on_enable_i(mode), .irq_o(irq), .iir_id_o(iid), .thre_o(thre)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata(input int a);
    case (a)
      1: return m_ier;
      2: return (m_fifo ? 8'hC0 : 8'h00) | (m_pend ? 2 : 1);
      5: return (m_cnt == 0) ? 8'h20 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(input int a);
    case (a)
      1: return "R11 ier readback";
      2: return "R3 iir read";
      5: return "R8 lsr read";
      default: return "R10 other read";
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_fifo = 0; m_ier = 0; m_pend = 0; m_spent = 0;
  endtask

  // behavioural model of one edge, from the requirements
  task automatic model_step(input int a, input bit r, input bit w, input int d, input bit t);
    int cap, nc, nier1, set, clr, ack, rise;
    bit thr_w, ier_w, fcr_w;
    thr_w = w && a == 0; ier_w = w && a == 1; fcr_w = w && a == 2;
    cap = m_fifo ? DEPTH : 1;
    ack = r && a == 2 && m_pend;
    nc = m_cnt;
    if (t && nc > 0) nc--;
    if (fcr_w && (d[2] || d[0] != m_fifo[0])) nc = 0;
    else if (thr_w && nc < cap) nc++;
    nier1 = ier_w ? d[1] : m_ier[1];
    rise = ier_w && !m_ier[1] && d[1];
    set = nier1 && ((m_cnt != 0 && nc == 0) || (rise && nc == 0 && (mode || !m_spent)));
    clr = ack || thr_w || (ier_w && !d[1]);
    if (set) m_pend = 1; else if (clr) m_pend = 0;
    if (thr_w) m_spent = 0; else if (ack && !set) m_spent = 1;
    m_cnt = nc;
    if (ier_w) m_ier = d & 8'h0F;
    if (fcr_w) m_fifo = d[0];
  endtask

  // one cycle: drive at negedge, compare, let the edge happen, update model
  task automatic cyc(input int a, input bit r, input bit w, input int d, input bit t);
    addr = a[2:0]; rd = r; wr = w; wdata = d[7:0]; take = t;
    #1;
    chk("R3 irq_o", irq, m_pend);
    chk("R3 iir_id_o", iid, m_pend ? 2 : 1);
    chk("R8 thre_o", thre, m_cnt == 0);
    if (r) chk(rd_tag(a), rdata, exp_rdata(a));
    @(posedge clk);
    model_step(a, r, w, d, t);
    @(negedge clk);
    rd = 0; wr = 0; take = 0;
  endtask

  task automatic idle();          cyc(0, 0, 0, 0, 0); endtask
  task automatic rdr(input int a); cyc(a, 1, 0, 0, 0); endtask
  task automatic wrr(input int a, input int d); cyc(a, 0, 1, d, 0); endtask
  task automatic tk();            cyc(0, 0, 0, 0, 1); endtask

  task automatic do_reset(input bit m);
    rst_n = 0; mode = m; model_reset();
    repeat (2) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 irq_o", irq, 0);
    chk("R1 iir_id_o", iid, 1);
    chk("R1 thre_o", thre, 1);
    rst_n = 1;
    @(negedge clk);
    rdr(1); rdr(2); rdr(5);
  endtask

  task automatic directed(input bit m);
    do_reset(m);
    wrr(2, 8'h01);           // R2: FIFO on, bits 7:6 of iir
    wrr(1, 8'h02);           // R5: first enable raises
    idle();
    chk("R5 raised on first enable", irq, 1);
    rdr(2);                  // R4: acknowledge
    chk("R4 cleared by iir read", irq, 0);
    wrr(1, 8'h00); wrr(1, 8'h02); idle();
    // R6 / R7: the policy decides here
    chk(m ? "R7 re-raised by enable edge" : "R6 stays quiet", irq, m);
    rdr(5);                  // R8: flag independent of interrupt
    rdr(0); rdr(3); rdr(1);  // R10: other reads
    rdr(2);
    wrr(0, 8'h55);           // R9: write clears
    chk("R9 cleared by write", irq, 0);
    tk(); idle();
    chk("R5 raised on drain", irq, 1);
    rdr(2); wrr(1, 8'h00); wrr(1, 8'h02); idle();
    chk(m ? "R7 second re-raise" : "R6 quiet after ack", irq, m);
    // R2: fill past capacity, then drain
    for (int i = 0; i < DEPTH + 3; i++) wrr(0, i);
    for (int i = 0; i < DEPTH + 2; i++) begin tk(); rdr(5); end
    wrr(1, 8'h00);           // R11: disable clears
    wrr(0, 1); wrr(0, 2);
    wrr(2, 8'h00);           // R2: turning FIFO off flushes
    rdr(2);
    wrr(0, 1); wrr(0, 2); rdr(5); tk(); rdr(5);
    wrr(1, 8'h0F); rdr(1);   // R11 readback
    wrr(0, 3); cyc(0, 0, 1, 4, 1); rdr(5);
    wrr(2, 8'h05); rdr(2);   // R2: bit 2 flush
  endtask

  task automatic random_phase(input int n);
    for (int i = 0; i < n; i++) begin
      int op, a;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      op = lfsr % 16;
      a = (lfsr >> 8) % 8;
      case (op)
        0, 1, 2:    cyc(a, 1, 0, 0, lfsr[20]);
        3, 4:       cyc(0, 0, 1, lfsr >> 12, lfsr[21]);
        5:          cyc(1, 0, 1, lfsr >> 12, lfsr[22]);
        6:          cyc(2, 0, 1, lfsr >> 12 & 8'hFB | (lfsr[23] ? 4 : 0), 0);
        7, 8, 9:    cyc(2, 1, 0, 0, lfsr[24]);
        default:    cyc(0, 0, 0, 0, lfsr[25]);
      endcase
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    directed(1'b0);
    random_phase(3000);
    directed(1'b1);
    random_phase(3000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule